// File: doc/BRIEF.md
# Square-Root Carry-Select Adder

This block is a purely combinational 20-bit adder. It takes two operands and a carry-in, and it returns a 20-bit sum and a carry-out. The datapath is cut into five groups. Each group is one bit wider than the group below it, so a carry that arrives late at a higher group meets a wider group that has had longer to settle. The worst-case delay therefore grows roughly with the square root of the width rather than linearly.

Every group first forms per-bit propagate and generate terms. From these it builds two candidate carry vectors in parallel: one assumes the group carry-in is 0 and the other assumes it is 1. The real carry from the group below drives a multiplexer that picks one vector. The group's sum bits are then formed from the chosen vector. The chosen group carry-out selects the next group's vector, and the top group's carry-out is the adder carry-out. The block holds no state and needs no clock or reset.

Top module: `sqrt_csel_adder`

## Requirements
- R1: For every input, `{cout, sum}` equals `op_a + op_b + cin` as an exact 21-bit value.
- R2: The groups are fixed at bits 0-1, 2-4, 5-8, 9-13 and 14-19. A carry made below any boundary reaches the lowest bit of the group above it: with `op_a` all ones below bit L, `op_b = 1` and `cin = 0`, the result is `1 << L` for L in {2, 5, 9, 14}.
- R3: Inside each group, the candidate carry vector that assumes carry-in 0 never holds a 1 in a position where the vector that assumes carry-in 1 holds a 0.
- R4: When every bit of a group propagates (`a ^ b` all ones in that group), the group carry-out equals its incoming carry.
- R5: When the top bit of a group generates (both operand bits 1), the group carry-out is 1. When the top bit of a group kills (both operand bits 0), the group carry-out is 0. Both hold whatever the incoming carry is.
- R6: With `op_a` all ones, `op_b = 0` and `cin = 1`, the carry crosses every group boundary: `sum = 0` and `cout = 1`.
- R7: With both operands 0 and `cin = 0`, the result is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 20 | First operand |
| op_b | input | 20 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 20 | Sum bits |
| cout | output | 1 | Carry out of bit 19 |

## Verification
Random operands with a random carry-in cover the general case, where the selection in most groups depends on the groups below. Vectors that make all twenty bits propagate force the carry-in through every multiplexer in turn, so a wrong select at any level shows up. Per-boundary vectors generate a carry just below one boundary, which exposes a misplaced group edge. Vectors that make one group fully propagate, generate at its top bit or kill at its top bit, each tried with both incoming carry values, separate the bypass case from the cases where the incoming carry must have no effect.

// File: rtl/csa_pkg.sv
// Package: shared constants for the square-root carry-select adder.
// The group layout is fixed by design. Widths are 2,3,4,5,6 from bit 0 upward.
package csa_pkg;
    localparam int ADD_W   = 20;
    localparam int NUM_GRP = 5;

    // Width of group i (fixed table, not derived from ADD_W).
    function automatic int grp_width(input int i);
        case (i)
            0:       return 2;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            4:       return 6;
            default: return 0;
        endcase
    endfunction

    // Lowest bit index of group i.
    function automatic int grp_low(input int i);
        int lo;
        lo = 0;
        for (int k = 0; k < i; k++) lo += grp_width(k);
        return lo;
    endfunction
endpackage

// File: rtl/csa_setup.sv
// Module: csa_setup
// Forms per-bit propagate (xor) and generate (and) terms for one group.
// Assumes nothing beyond W >= 1.
module csa_setup #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] p,
    output logic [W-1:0] g
);
    // Bitwise propagate/generate terms.
    always_comb begin
        p = a ^ b;
        g = a & b;
    end
endmodule

// File: rtl/csa_chain.sv
// Module: csa_chain
// Ripple carry chain over one group with a constant assumed carry-in CIN.
// Output c[0] is the assumed carry-in; c[W] is the group carry-out.
module csa_chain #(
    parameter int W   = 4,
    parameter bit CIN = 1'b0
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] g,
    output logic [W:0]   c
);
    assign c[0] = CIN;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // Carry into bit i+1: generated here or propagated from below.
            assign c[i+1] = g[i] | (p[i] & c[i]);
        end
    endgenerate
endmodule

// File: rtl/csa_group.sv
// Module: csa_group
// One carry-select group: setup, two candidate chains, select by ci, sum.
// Assumes ci arrives from the group below (or the adder carry-in).
module csa_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int WP = W + 1;

    logic [W-1:0] p, g;
    logic [W:0]   c_zero, c_one, c_sel;

    csa_setup #(.W(W)) u_setup (.a(a), .b(b), .p(p), .g(g));

    csa_chain #(.W(W), .CIN(1'b0)) u_chain0 (.p(p), .g(g), .c(c_zero));
    csa_chain #(.W(W), .CIN(1'b1)) u_chain1 (.p(p), .g(g), .c(c_one));

    // Pick the candidate carry vector using the real incoming carry.
    always_comb c_sel = ci ? c_one : c_zero;

    // Sum bits come from propagate and the selected carries.
    always_comb begin
        s  = p ^ c_sel[W-1:0];
        co = c_sel[W];
    end

    // Group-level checks (skipped while inputs are still unknown).
    always_comb begin
        if (!$isunknown({a, b, ci})) begin
            p_cand_order_r3: assert ((c_zero & ~c_one) == '0)
                else $error("R3: carry-0 candidate exceeds carry-1 candidate");
            if (&(a ^ b)) begin
                p_bypass_r4: assert (co == ci)
                    else $error("R4: full-propagate group did not pass its carry");
            end
            if (a[W-1] & b[W-1]) begin
                p_top_gen_r5: assert (co == 1'b1)
                    else $error("R5: generating top bit gave no carry-out");
            end
            if (!a[W-1] && !b[W-1]) begin
                p_top_kill_r5: assert (co == 1'b0)
                    else $error("R5: killing top bit gave a carry-out");
            end
            p_group_sum_r1: assert ({co, s} == ({1'b0, a} + {1'b0, b} + WP'(ci)))
                else $error("R1: group result wrong");
        end
    end
endmodule

// File: rtl/sqrt_csel_adder.sv
// Module: sqrt_csel_adder (top)
// 20-bit carry-select adder with groups of 2,3,4,5,6 bits (R2). Each group's
// selected carry-out drives the next group's select. Purely combinational.
module sqrt_csel_adder
    import csa_pkg::*;
(
    input  logic [ADD_W-1:0] op_a,
    input  logic [ADD_W-1:0] op_b,
    input  logic             cin,
    output logic [ADD_W-1:0] sum,
    output logic             cout
);
    localparam int RES_W = ADD_W + 1;

    logic [NUM_GRP:0] grp_c;

    assign grp_c[0] = cin;

    genvar k;
    generate
        for (k = 0; k < NUM_GRP; k++) begin : g_grp
            localparam int LO = grp_low(k);
            localparam int GW = grp_width(k);
            csa_group #(.W(GW)) u_group (
                .a (op_a[LO +: GW]),
                .b (op_b[LO +: GW]),
                .ci(grp_c[k]),
                .s (sum[LO +: GW]),
                .co(grp_c[k+1])
            );
        end
    endgenerate

    // Adder carry-out is the top group's selected carry.
    assign cout = grp_c[NUM_GRP];

    // Whole-adder exactness check.
    always_comb begin
        if (!$isunknown({op_a, op_b, cin})) begin
            p_sum_exact_r1: assert ({cout, sum} == ({1'b0, op_a} + {1'b0, op_b} + RES_W'(cin)))
                else $error("R1: adder result wrong");
            if (op_a == '1 && op_b == '0 && cin) begin
                p_full_ripple_r6: assert (cout && sum == '0)
                    else $error("R6: carry did not cross all groups");
            end
        end
    end
endmodule

// File: tb/test_sqrt_csel_adder.sv
// Bench: random plus directed vectors against a reference sum.
module test_sqrt_csel_adder;
    logic        clk = 1'b0;
    logic [19:0] op_a, op_b, sum;
    logic        cin, cout;
    int          n_tests = 0;
    int          n_fail  = 0;
    bit          done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sqrt_csel_adder i_sqrt_csel_adder (
        .op_a(op_a), .op_b(op_b), .cin(cin), .sum(sum), .cout(cout)
    );

    function automatic logic [20:0] ref_add(input logic [19:0] a, input logic [19:0] b,
                                            input logic c);
        return {1'b0, a} + {1'b0, b} + {20'd0, c};
    endfunction

    // Drive at a rising edge, compare at the next falling edge.
    task automatic run(input string req, input logic [19:0] a, input logic [19:0] b,
                       input logic c);
        logic [20:0] exp;
        @(posedge clk);
        op_a = a; op_b = b; cin = c;
        @(negedge clk);
        exp = ref_add(a, b, c);
        n_tests++;
        if ({cout, sum} !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b got=%h exp=%h", req, a, b, c, {cout, sum}, exp);
        end
    endtask

    // Group edges: 0,2,5,9,14,20.
    localparam int LO [6] = '{0, 2, 5, 9, 14, 20};

    initial begin
        void'($urandom(32'd1234));
        op_a = '0; op_b = '0; cin = 1'b0;
        // R7: all-zero inputs.
        run("R7", 20'h0, 20'h0, 1'b0);
        // R6: carry through every group.
        run("R6", 20'hFFFFF, 20'h0, 1'b1);
        run("R6", 20'h0, 20'hFFFFF, 1'b1);
        run("R1", 20'hFFFFF, 20'hFFFFF, 1'b1);
        run("R1", 20'hFFFFF, 20'hFFFFF, 1'b0);
        // R2: carry generated just below each boundary.
        for (int k = 1; k < 5; k++) begin
            logic [19:0] m;
            m = 20'((32'd1 << LO[k]) - 1);
            run("R2", m, 20'h1, 1'b0);
        end
        // R4 and R5: per-group propagate, generate and kill, with both carries.
        for (int k = 0; k < 5; k++) begin
            logic [19:0] gm;
            gm = 20'(((32'd1 << LO[k+1]) - 1) & ~((32'd1 << LO[k]) - 1));
            for (int c = 0; c < 2; c++) begin
                run("R4", 20'hAAAAA & gm, 20'h55555 & gm, 1'(c));
                run("R4", gm, 20'h0 | (gm == 20'h3 ? 20'h0 : 20'h1), 1'(c));
                run("R5", gm, gm, 1'(c));
                run("R5", 20'hFFFFF & ~gm, 20'h1, 1'(c));
            end
        end
        // R3 and R1: random operands and carry-in.
        for (int n = 0; n < 2000; n++) begin
            run((n % 2) ? "R1" : "R3", 20'($urandom), 20'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    // Summary and finish; an expired watchdog counts as a failed check.
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_fail++;
                n_tests++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule